// File: doc/BRIEF.md
# Serial LED Status Shifter

The block collects the status bits of an eight-port hub and sends them to an external LED driver over two wires: a gated serial clock and a data line. The status bits are:

- a partition flag for each port,
- a receive-activity flag for each port,
- one collision flag for the lower-speed domain and one for the higher-speed domain,
- a flag that reports a failed memory self-test.

Once in every refresh interval the block takes a snapshot of all these bits as a 24-bit frame. It then sends the frame as a burst of 24 serial clock cycles, starting with the least significant bit. Between bursts the serial clock stays low and the data line keeps its last value.

The block runs from a 50 MHz system clock. Each serial bit lasts 8 system clocks (160 ns): the clock is low for the first half of the bit and high for the second half. Data changes only while the clock is low, so the driver can latch each bit on the rising edge. The default refresh interval is 2,100,000 system clocks (42 ms). It is a parameter so that simulation can use a shorter interval. Reset is synchronous and active low.

Top module: `led_status_serializer`

## Requirements
- R1: Each burst contains exactly 24 rising edges of `led_clk`. After the last rising edge, `led_clk` returns low and stays low until the next burst.
- R2: Each serial bit lasts `CLKS_PER_BIT` system clocks (default 8). `led_clk` is low for the first half of the bit and high for the second half (4 and 4 at the default).
- R3: Frame bit k is present on `led_data` at the (k+1)-th rising edge of a burst. Bit 0 goes first and bit 23 goes last.
- R4: Frame bits 0 to 7 carry `port_partition[0]` to `port_partition[7]`.
- R5: Frame bit 8 carries `col_slow`, bit 9 carries `col_fast`, and bit 10 carries `mem_fail`.
- R6: Frame bits 11 to 15 repeat `port_partition[3]` to `port_partition[7]`.
- R7: Frame bits 16 to 23 carry `port_rx_act[0]` to `port_rx_act[7]`.
- R8: `led_data` changes only while `led_clk` is low. It is stable for every cycle in which `led_clk` is high.
- R9: All 24 bits of a burst come from the input values at the system clock edge that starts the burst. Input changes during the burst do not affect it.
- R10: Between bursts, `led_clk` is low and `led_data` holds the value of the last bit sent.
- R11: While reset is asserted, `led_clk` and `led_data` are low and the refresh counter is cleared. The first burst starts `REFRESH_CLKS` system clocks after reset is released. Its first rising edge of `led_clk` therefore appears `CLKS_PER_BIT/2` clocks after that.
- R12: Successive bursts start exactly `REFRESH_CLKS` system clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 50 MHz nominal |
| rst_n | input | 1 | Synchronous reset, active low |
| port_partition | input | 8 | Partition flag of each port |
| port_rx_act | input | 8 | Receive-activity flag of each port |
| col_slow | input | 1 | Collision flag, lower-speed domain |
| col_fast | input | 1 | Collision flag, higher-speed domain |
| mem_fail | input | 1 | Memory self-test failure flag |
| led_clk | output | 1 | Gated serial clock to the LED driver |
| led_data | output | 1 | Serial data to the LED driver |

## Verification
The assertions check the following on every cycle:

- the width of each high phase of `led_clk`,
- that `led_data` is stable while `led_clk` is high,
- that the line is quiet between bursts,
- that a burst ends only after its last bit,
- that the refresh counter stays within range.

Only the bench scenarios can show the cycle at which the first burst starts after reset, the spacing between bursts, the content and order of each field in the frame, and that the frame is frozen when the burst starts even if the inputs change during the burst.

// File: rtl/led_ser_pkg.sv
// Package: shared frame type and constants for the serial LED status shifter.
// Assumes an eight-port hub; the frame layout is fixed by the LED driver.
package led_ser_pkg;

    localparam int PORTS   = 8;
    localparam int FRAME_W = 24;
    localparam int HI_REP  = 5;   // ports 3..7 repeated in the upper partition field

    typedef logic [FRAME_W-1:0] led_frame_t;

    // Frame layout: bit 0 is sent first. Packed structs list the MSB first.
    typedef struct packed {
        logic [PORTS-1:0]  rx_act;    // bits 23:16
        logic [HI_REP-1:0] part_rep;  // bits 15:11
        logic              mem_fail;  // bit 10
        logic              col_fast;  // bit 9
        logic              col_slow;  // bit 8
        logic [PORTS-1:0]  part;      // bits 7:0
    } led_frame_s;

endpackage

// File: rtl/led_frame_pack.sv
// Module: led_frame_pack
// Maps the status inputs onto the fixed 24-bit LED frame. This module is purely
// combinational. It assumes that the status inputs are already synchronous to clk.
module led_frame_pack
    import led_ser_pkg::*;
(
    input  logic [PORTS-1:0] part,
    input  logic [PORTS-1:0] rx_act,
    input  logic             col_slow,
    input  logic             col_fast,
    input  logic             mem_fail,
    output led_frame_t       frame
);

    led_frame_s fs;

    // Place each status field at its position in the frame.
    always_comb begin
        fs.part     = part;
        fs.col_slow = col_slow;
        fs.col_fast = col_fast;
        fs.mem_fail = mem_fail;
        fs.part_rep = part[PORTS-1:PORTS-HI_REP];
        fs.rx_act   = rx_act;
        frame       = led_frame_t'(fs);
    end

endmodule

// File: rtl/led_refresh_timer.sv
// Module: led_refresh_timer
// Free-running counter that pulses tick once every REFRESH_CLKS clocks.
// After reset the counter starts from zero, so the first tick arrives after
// one full interval.
module led_refresh_timer #(
    parameter int REFRESH_CLKS = 2_100_000,
    localparam int CNT_W = (REFRESH_CLKS > 1) ? $clog2(REFRESH_CLKS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             tick,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(REFRESH_CLKS - 1);

    // Decode the last count of the interval.
    always_comb tick = (cnt == LAST);

    // Count, wrapping to zero at the end of each interval.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/led_serial_shifter.sv
// Module: led_serial_shifter
// On start it captures a frame and shifts it out least significant bit first.
// Each bit lasts CLKS_PER_BIT clocks: the serial clock is low for the first
// half and high for the second half. Data changes when the serial clock goes low.
// A start pulse that arrives while a burst is in progress is ignored.
// Assumes that CLKS_PER_BIT is even and at least 2.
module led_serial_shifter #(
    parameter int CLKS_PER_BIT = 8,
    parameter int FRAME_W      = 24,
    localparam int PH_W  = $clog2(CLKS_PER_BIT),
    localparam int IDX_W = $clog2(FRAME_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame,
    output logic               ser_clk,
    output logic               ser_data,
    output logic               busy,
    output logic [IDX_W-1:0]   bit_idx
);

    localparam logic [PH_W-1:0]  PH_RISE = PH_W'(CLKS_PER_BIT / 2 - 1);
    localparam logic [PH_W-1:0]  PH_LAST = PH_W'(CLKS_PER_BIT - 1);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(FRAME_W - 1);

    logic [PH_W-1:0]    phase;
    logic [FRAME_W-1:0] shreg;
    logic               bit_end;

    // Mark the last system clock of the current bit.
    always_comb bit_end = busy && (phase == PH_LAST);

    // Track the phase within a bit and the index of the current bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            phase   <= '0;
            bit_idx <= '0;
        end else if (!busy) begin
            if (start) begin
                busy    <= 1'b1;
                phase   <= '0;
                bit_idx <= '0;
            end
        end else if (bit_end) begin
            phase <= '0;
            if (bit_idx == IDX_END) busy <= 1'b0;
            else                    bit_idx <= bit_idx + 1'b1;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    // Hold the captured frame and advance it at each bit boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  shreg <= '0;
        else if (!busy && start)                     shreg <= frame;
        else if (bit_end && (bit_idx != IDX_END))    shreg <= shreg >> 1;
    end

    // Drive the serial clock: high in the second half of each bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                          ser_clk <= 1'b0;
        else if (busy && phase == PH_RISE)   ser_clk <= 1'b1;
        else if (bit_end)                    ser_clk <= 1'b0;
    end

    // Drive the data line: load the first bit at start, then the next bit when
    // the clock falls; keep the value between bursts.
    always_ff @(posedge clk) begin
        if (!rst_n)                               ser_data <= 1'b0;
        else if (!busy && start)                  ser_data <= frame[0];
        else if (bit_end && (bit_idx != IDX_END)) ser_data <= shreg[1];
    end

endmodule

// File: rtl/led_status_serializer.sv
// Module: led_status_serializer (top)
// Sends the hub status frame over a gated serial clock and data line once per
// refresh interval. Assumes a 50 MHz clk, status inputs synchronous to clk, and
// a refresh interval longer than one burst.
module led_status_serializer
    import led_ser_pkg::*;
#(
    parameter int REFRESH_CLKS = 2_100_000,
    parameter int CLKS_PER_BIT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PORTS-1:0] port_partition,
    input  logic [PORTS-1:0] port_rx_act,
    input  logic             col_slow,
    input  logic             col_fast,
    input  logic             mem_fail,
    output logic             led_clk,
    output logic             led_data
);

    localparam int CNT_W = (REFRESH_CLKS > 1) ? $clog2(REFRESH_CLKS) : 1;
    localparam int IDX_W = $clog2(FRAME_W);

    // Reject parameter values that would make bursts overlap or give an uneven bit.
    if (REFRESH_CLKS <= CLKS_PER_BIT * FRAME_W) begin : g_bad_refresh
        $error("REFRESH_CLKS must exceed one burst length");
    end
    if ((CLKS_PER_BIT < 2) || (CLKS_PER_BIT % 2 != 0)) begin : g_bad_bit
        $error("CLKS_PER_BIT must be even and at least 2");
    end

    led_frame_t       frame;
    logic             tick;
    logic [CNT_W-1:0] ref_cnt;
    logic             busy;
    logic [IDX_W-1:0] bit_idx;

    led_frame_pack u_pack (
        .part     (port_partition),
        .rx_act   (port_rx_act),
        .col_slow (col_slow),
        .col_fast (col_fast),
        .mem_fail (mem_fail),
        .frame    (frame)
    );

    led_refresh_timer #(.REFRESH_CLKS(REFRESH_CLKS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .cnt   (ref_cnt)
    );

    led_serial_shifter #(.CLKS_PER_BIT(CLKS_PER_BIT), .FRAME_W(FRAME_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (tick),
        .frame    (frame),
        .ser_clk  (led_clk),
        .ser_data (led_data),
        .busy     (busy),
        .bit_idx  (bit_idx)
    );

endmodule

// File: rtl/led_status_serializer_chk.sv
// Module: led_status_serializer_chk
// Checker bound to the top module. It checks the serial line protocol and the
// internal timing state on every cycle.
module led_status_serializer_chk #(
    parameter int REFRESH_CLKS = 2_100_000,
    parameter int CLKS_PER_BIT = 8,
    parameter int FRAME_W      = 24,
    localparam int CNT_W = (REFRESH_CLKS > 1) ? $clog2(REFRESH_CLKS) : 1,
    localparam int IDX_W = $clog2(FRAME_W)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             led_clk,
    input logic             led_data,
    input logic             busy,
    input logic [IDX_W-1:0] bit_idx,
    input logic [CNT_W-1:0] ref_cnt
);

    logic [7:0] hi_len;

    // Count consecutive cycles with the serial clock high.
    always_ff @(posedge clk) begin
        if (!rst_n)       hi_len <= '0;
        else if (led_clk) hi_len <= hi_len + 1'b1;
        else              hi_len <= '0;
    end

    AST_HIGH_HALF_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(led_clk) |-> (hi_len == 8'(CLKS_PER_BIT / 2)));  // R2
    AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (led_clk && $past(led_clk)) |-> $stable(led_data));  // R8
    AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> !led_clk);  // R10
    AST_IDLE_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> $stable(led_data));  // R10
    AST_BURST_END_LAST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(bit_idx) == IDX_W'(FRAME_W - 1)));  // R1
    AST_BIT_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_idx < IDX_W'(FRAME_W));  // R1
    AST_REFRESH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cnt <= CNT_W'(REFRESH_CLKS - 1));  // R12

endmodule

bind led_status_serializer led_status_serializer_chk #(
    .REFRESH_CLKS (REFRESH_CLKS),
    .CLKS_PER_BIT (CLKS_PER_BIT),
    .FRAME_W      (24)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .led_clk  (led_clk),
    .led_data (led_data),
    .busy     (busy),
    .bit_idx  (bit_idx),
    .ref_cnt  (ref_cnt)
);

// File: tb/test_led_status_serializer.sv
`timescale 1ns/100ps
// Directed bench for led_status_serializer with a shortened refresh interval.
module test_led_status_serializer;

    localparam int REF = 400;
    localparam int CPB = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] part = '0;
    logic [7:0] act = '0;
    logic       cs = 1'b0;
    logic       cf = 1'b0;
    logic       mf = 1'b0;
    logic       led_clk;
    logic       led_data;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    // Values applied after the first rising edge of a burst (used by the R9 scenario).
    logic [7:0] alt_part = '0;
    logic [7:0] alt_act = '0;

    always #2.5 clk = ~clk;

    // Count clock edges since reset was released.
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    led_status_serializer #(.REFRESH_CLKS(REF), .CLKS_PER_BIT(CPB)) i_led_status_serializer (
        .clk            (clk),
        .rst_n          (rst_n),
        .port_partition (part),
        .port_rx_act    (act),
        .col_slow       (cs),
        .col_fast       (cf),
        .mem_fail       (mf),
        .led_clk        (led_clk),
        .led_data       (led_data)
    );

    task automatic chk(input bit ok, input string req, input longint act_v, input longint exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act_v, exp_v);
        end
    endtask

    // Build the expected frame from the field layout given in the requirements.
    function automatic logic [23:0] exp_frame(input logic [7:0] p, input logic [7:0] a,
                                              input logic s, input logic f, input logic m);
        logic [23:0] w;
        w[7:0]   = p;      // R4
        w[8]     = s;      // R5
        w[9]     = f;
        w[10]    = m;
        w[15:11] = p[7:3]; // R6
        w[23:16] = a;      // R7
        return w;
    endfunction

    // Wait for a burst, capture it, and report its shape.
    task automatic capture(input bit flip, output logic [23:0] w, output int rise_cyc,
                           output int nrise, output int bad_w, output int unstable);
        bit prev = 0;
        int hi = 0;
        int lo = 0;
        logic dhold = 0;
        int guard = 0;
        w = '0; nrise = 0; bad_w = 0; unstable = 0; rise_cyc = -1;
        do begin
            @(negedge clk);
            guard++;
        end while (!led_clk && guard < 4 * REF);
        rise_cyc = cyc;
        forever begin
            if (led_clk && !prev) begin
                nrise++;
                if (nrise <= 24) w[nrise-1] = led_data;
                if (nrise > 1 && lo != CPB / 2) bad_w++;
                hi = 1; dhold = led_data;
                if (flip && nrise == 1) begin part = alt_part; act = alt_act; cs = ~cs; end
            end else if (led_clk) begin
                hi++;
                if (led_data !== dhold) unstable++;
            end else if (prev) begin
                if (hi != CPB / 2) bad_w++;
                lo = 1;
            end else begin
                lo++;
            end
            prev = led_clk;
            if (!led_clk && lo > 2 * CPB) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        part = 8'hFF; act = 8'hFF; cs = 1; cf = 1; mf = 1;
        repeat (5) @(negedge clk);
        chk(led_clk === 1'b0, "R11 clk low in reset", led_clk, 0);
        chk(led_data === 1'b0, "R11 data low in reset", led_data, 0);
        part = 8'hA5; act = 8'h3C; cs = 1; cf = 0; mf = 1;
        rst_n = 1'b1;
    endtask

    task automatic t_first_burst();
        logic [23:0] w, e;
        int rc, nr, bw, us;
        e = exp_frame(8'hA5, 8'h3C, 1, 0, 1);
        capture(0, w, rc, nr, bw, us);
        chk(rc == REF + CPB / 2, "R11 first rise cycle", rc, REF + CPB / 2);
        chk(nr == 24, "R1 rising edges", nr, 24);
        chk(bw == 0, "R2 half-bit widths", bw, 0);
        chk(us == 0, "R8 data stable while high", us, 0);
        chk(w[7:0] == e[7:0], "R4 partition field", w[7:0], e[7:0]);
        chk(w[10:8] == e[10:8], "R5 collision and memfail", w[10:8], e[10:8]);
        chk(w[15:11] == e[15:11], "R6 repeated partition", w[15:11], e[15:11]);
        chk(w[23:16] == e[23:16], "R7 activity field", w[23:16], e[23:16]);
        chk(w == e, "R3 bit order", w, e);
    endtask

    task automatic t_second_burst_and_idle();
        logic [23:0] w, e;
        int rc, nr, bw, us, bad;
        part = 8'h5A; act = 8'hC1; cs = 0; cf = 1; mf = 0;
        e = exp_frame(8'h5A, 8'hC1, 0, 1, 0);
        capture(0, w, rc, nr, bw, us);
        chk(rc == 2 * REF + CPB / 2, "R12 burst spacing", rc, 2 * REF + CPB / 2);
        chk(w == e, "R3 second frame", w, e);
        chk(nr == 24 && bw == 0, "R1 second burst shape", nr, 24);
        // Change the inputs between bursts; the line must stay quiet and hold the last bit.
        part = ~part; act = ~act; cs = ~cs;
        bad = 0;
        repeat (100) begin
            @(negedge clk);
            if (led_clk !== 1'b0 || led_data !== e[23]) bad++;
        end
        chk(bad == 0, "R10 idle line", bad, 0);
    endtask

    task automatic t_snapshot();
        logic [23:0] w, e;
        int rc, nr, bw, us;
        part = 8'h81; act = 8'h7E; cs = 1; cf = 1; mf = 0;
        e = exp_frame(8'h81, 8'h7E, 1, 1, 0);
        alt_part = 8'h7E; alt_act = 8'h81;
        capture(1, w, rc, nr, bw, us);
        chk(w == e, "R9 snapshot at burst start", w, e);
        chk(rc == 3 * REF + CPB / 2, "R12 third burst spacing", rc, 3 * REF + CPB / 2);
    endtask

    initial begin
        t_reset();
        t_first_burst();
        t_second_burst_and_idle();
        t_snapshot();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check and still reports the summary.
    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule